// File: doc/BRIEF.md
# Fully associative translation buffer with access protection

This block keeps a small set of recent virtual-to-physical page translations and answers lookups against all of them at once. A requester presents a virtual page number together with the kind of access it wants to make: load, store or instruction fetch. In the same cycle the block reports whether the translation is present. On a hit it also reports the physical page number, whether the stored rights forbid the access, and whether the page is already marked as written. A faulting access still reports a hit, so the requester can tell a rights problem apart from a missing translation.

After a miss, the hardware table walker supplies the translation on the fill port. The block itself chooses the slot that receives it. It takes the lowest-numbered empty slot if there is one. Otherwise it takes the lowest-numbered slot whose use bit is clear. The use bits follow a clear-on-saturation scheme that approximates least-recently-used order. The chosen slot and whether it holds a written page are visible at all times, so the walker can schedule a write-back before it replaces that page. A flush input empties the whole buffer in one cycle.

Top module: `xlate_tlb`

## Requirements
- R1: While `lk_valid` is high, `lk_hit` is high in the same cycle exactly when a valid entry's tag equals `lk_vpn`. While `lk_valid` is low, `lk_hit` is low.
- R2: On a hit, `lk_ppn` carries the physical page number stored with the matching entry. On a miss, `lk_ppn` is zero and `lk_fault` is low.
- R3: Rights are three bits: bit 0 allows load, bit 1 allows store, bit 2 allows fetch. `lk_kind` encodes the access as 0 = load, 1 = store, 2 = fetch and 3 = reserved, and a reserved access is never allowed. On a hit whose access is not allowed, `lk_fault` is high and `lk_hit` stays high.
- R4: A fill takes effect at the next clock edge. It writes the slot shown on `vict_idx` in the fill cycle, marks that slot valid and clean, and the new translation hits from the following cycle on.
- R5: If any entry is invalid, `vict_idx` is the lowest index among the invalid entries.
- R6: If every entry is valid, `vict_idx` is the lowest index whose use bit is clear.
- R7: A lookup hit outside a fill cycle sets the use bit of the matching entry, and a fill sets the use bit of the slot it writes. If that would leave every use bit set, all use bits are cleared except the one just set.
- R8: A store hit that the rights allow marks the entry written. `lk_dirty` reports the hit entry's written mark as it stood before the access. Loads, fetches and faulting stores leave the mark unchanged.
- R9: `vict_dirty` is high exactly when the slot shown on `vict_idx` is valid and marked written.
- R10: When `fill_vpn` equals the tag of a valid entry, `vict_idx` points at that entry, and the fill replaces it in place, so no tag is ever held twice.
- R11: A flush clears every valid bit and every use bit at the next edge. It takes priority over a fill or a lookup update in the same cycle.
- R12: In a cycle with `fill_en` high, the lookup outputs are still produced, but the lookup changes neither use bits nor written marks.
- R13: After reset every entry is invalid, no lookup hits, `vict_idx` is 0 and `vict_dirty` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_hit | output | 1 | Translation present |
| lk_fault | output | 1 | Hit whose rights forbid the access |
| lk_ppn | output | PPN_W | Physical page number, zero on a miss |
| lk_dirty | output | 1 | Hit entry is already marked written |
| fill_en | input | 1 | Write a translation at the next edge |
| fill_vpn | input | VPN_W | Virtual page number of the new translation |
| fill_ppn | input | PPN_W | Physical page number of the new translation |
| fill_perm | input | 3 | Rights of the new translation |
| vict_idx | output | $clog2(ENTRIES) | Slot the next fill will write |
| vict_dirty | output | 1 | That slot holds a valid, written page |

## Verification
In an 8-entry, 6-bit configuration, every one of the 64 virtual page numbers is looked up with all four access kinds while the buffer holds entries carrying each of the eight rights codes. This separates true misses, clean hits, rights faults and reserved-kind faults. The fill sequences cover an empty buffer, a full one, and a buffer refilled after a flush, which exercises the three victim rules: lowest empty slot, lowest clear use bit, and in-place refill of a tag already held. Interleaved store hits make the written marks and the victim write-back flag change. Lookups issued alongside fills, and a flush issued alongside both, show which update wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef logic [PERM_W-1:0] perm_t;

  // Rights check for one access against one entry's permission bits.
  function automatic logic perm_allows(perm_t p, acc_e k);
    logic ok;
    case (k)
      ACC_LOAD:  ok = p[PERM_RD];
      ACC_STORE: ok = p[PERM_WR];
      ACC_FETCH: ok = p[PERM_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare across all entries; one-hot hit vector plus encoded index.
module tlb_match #(
  parameter  int ENTRIES = 64,
  parameter  int VPN_W   = 20,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]   key,
  input  logic [VPN_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  output logic [ENTRIES-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end

  assign any = |hits;

  // OR-encoder: valid because at most one entry can match (refill in place).
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
// Replacement choice: lowest empty slot, else lowest slot with use bit clear.
module tlb_victim #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] used,
  output logic [IDX_W-1:0]   pick
);

  logic [IDX_W-1:0] empty_idx;
  logic             empty_any;
  logic [IDX_W-1:0] cold_idx;

  always_comb begin
    empty_idx = '0;
    empty_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        empty_idx = IDX_W'(i);
        empty_any = 1'b1;
      end
    end
  end

  always_comb begin
    cold_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!used[i]) cold_idx = IDX_W'(i);
    end
  end

  assign pick = empty_any ? empty_idx : cold_idx;

endmodule

// File: rtl/tlb_store.sv
// Tag and payload arrays: single write port, asynchronous read (distributed RAM).
module tlb_store
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 64,
  parameter  int VPN_W   = 20,
  parameter  int PPN_W   = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  perm_t            wr_perm,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn,
  output perm_t            rd_perm,
  output logic [VPN_W-1:0] tags [ENTRIES]
);

  logic [VPN_W-1:0] tag_mem  [ENTRIES];
  logic [PPN_W-1:0] ppn_mem  [ENTRIES];
  perm_t            perm_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_vpn;
      ppn_mem[wr_idx]  <= wr_ppn;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  assign rd_ppn  = ppn_mem[rd_idx];
  assign rd_perm = perm_mem[rd_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tag_out
    assign tags[g] = tag_mem[g];
  end

endmodule

// File: rtl/tlb_state.sv
// Per-entry valid, use and written bits with the saturating use-bit update.
module tlb_state #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               use_en,
  input  logic [IDX_W-1:0]   use_idx,
  input  logic               set_dirty,
  output logic [ENTRIES-1:0] valid_q,
  output logic [ENTRIES-1:0] used_q,
  output logic [ENTRIES-1:0] dirty_q
);

  logic [ENTRIES-1:0] touch;
  logic [ENTRIES-1:0] merged;
  logic [ENTRIES-1:0] used_d;

  always_comb begin
    touch = '0;
    if (fill_en)     touch[fill_idx] = 1'b1;
    else if (use_en) touch[use_idx]  = 1'b1;
  end

  assign merged = used_q | touch;
  assign used_d = (|touch && &merged) ? touch : merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      used_q  <= '0;
      dirty_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      used_q <= used_d;
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
      end else if (set_dirty) begin
        dirty_q[use_idx] <= 1'b1;
      end
    end
  end

  // R7: the use bits never all stay set, so a cold victim always exists.
  a_r7_use_not_saturated: assert property (@(posedge clk) disable iff (rst)
    !(&used_q));

  // R4: a fill leaves its slot valid at the next edge.
  a_r4_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> valid_q[$past(fill_idx)]);

  // R8: a permitted store hit leaves the entry marked written.
  a_r8_store_marks_dirty: assert property (@(posedge clk) disable iff (rst)
    (set_dirty && !fill_en && !flush) |=> dirty_q[$past(use_idx)]);

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 64,
  parameter  int VPN_W   = 20,
  parameter  int PPN_W   = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [2:0]       fill_perm,
  output logic [IDX_W-1:0] vict_idx,
  output logic             vict_dirty
);

  logic [VPN_W-1:0]   tags [ENTRIES];
  logic [ENTRIES-1:0] valid_q, used_q, dirty_q;
  logic [ENTRIES-1:0] lk_hits, fl_hits;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx, free_idx;
  logic [PPN_W-1:0]   rd_ppn;
  perm_t              rd_perm;
  acc_e               kind;
  logic               allowed, use_en, set_dirty;

  assign kind = acc_e'(lk_kind);

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .key(lk_vpn), .tags(tags), .valid(valid_q),
    .hits(lk_hits), .any(lk_any), .idx(lk_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_match (
    .key(fill_vpn), .tags(tags), .valid(valid_q),
    .hits(fl_hits), .any(fl_any), .idx(fl_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid(valid_q), .used(used_q), .pick(free_idx)
  );

  assign vict_idx   = fl_any ? fl_idx : free_idx;
  assign vict_dirty = valid_q[vict_idx] && dirty_q[vict_idx];

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .wr_en(fill_en && !flush), .wr_idx(vict_idx),
    .wr_vpn(fill_vpn), .wr_ppn(fill_ppn), .wr_perm(perm_t'(fill_perm)),
    .rd_idx(lk_idx), .rd_ppn(rd_ppn), .rd_perm(rd_perm), .tags(tags)
  );

  assign allowed   = perm_allows(rd_perm, kind);
  assign lk_hit    = lk_valid && lk_any;
  assign lk_fault  = lk_hit && !allowed;
  assign lk_ppn    = lk_hit ? rd_ppn : '0;
  assign lk_dirty  = lk_hit && dirty_q[lk_idx];
  assign use_en    = lk_hit && !fill_en;
  assign set_dirty = use_en && (kind == ACC_STORE) && allowed;

  tlb_state #(.ENTRIES(ENTRIES)) u_state (
    .clk(clk), .rst(rst), .flush(flush),
    .fill_en(fill_en), .fill_idx(vict_idx),
    .use_en(use_en), .use_idx(lk_idx), .set_dirty(set_dirty),
    .valid_q(valid_q), .used_q(used_q), .dirty_q(dirty_q)
  );

  // R10: refill in place keeps every tag unique, so at most one entry matches.
  a_r10_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hits));

  // R3: a fault is only ever reported together with a hit.
  a_r3_fault_needs_hit: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> lk_hit);

  // R11: the cycle after a flush nothing can hit.
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);

  // R2: a miss returns a zero page number.
  a_r2_miss_zero_ppn: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_ppn == '0));

endmodule

// File: tb/xlate_tlb_tb.sv
`timescale 1ns/1ps
module xlate_tlb_tb;
  localparam int N  = 8;
  localparam int VW = 6;
  localparam int PW = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst, flush, lk_valid, fill_en;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [1:0]    lk_kind;
  logic [PW-1:0] fill_ppn, lk_ppn;
  logic [2:0]    fill_perm;
  logic          lk_hit, lk_fault, lk_dirty, vict_dirty;
  logic [IW-1:0] vict_idx;

  always #2.5 clk = ~clk;

  xlate_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .vict_idx(vict_idx), .vict_dirty(vict_dirty)
  );

  // Bench model of the buffer contents, updated from the requirements.
  logic          m_v [N], m_u [N], m_d [N];
  logic [VW-1:0] m_tag [N];
  logic [PW-1:0] m_ppn [N];
  logic [2:0]    m_perm [N];
  int errs = 0, checks = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_find(logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == v) return i;
    return -1;
  endfunction

  function automatic bit m_allow(logic [2:0] p, logic [1:0] k);
    if (k == 2'd3) return 1'b0;
    return p[k];
  endfunction

  function automatic int m_victim(logic [VW-1:0] v, output string why);
    int f;
    f = m_find(v);
    if (f >= 0) begin why = "R10 victim"; return f; end
    for (int i = 0; i < N; i++) if (!m_v[i]) begin why = "R5 victim"; return i; end
    for (int i = 0; i < N; i++) if (!m_u[i]) begin why = "R6 victim"; return i; end
    why = "R6 victim";
    return 0;
  endfunction

  task automatic m_touch(int i);
    bit all;
    m_u[i] = 1'b1;
    all = 1'b1;
    for (int j = 0; j < N; j++) all &= m_u[j];
    if (all) for (int j = 0; j < N; j++) m_u[j] = (j == i);
  endtask

  task automatic step(bit lv, logic [VW-1:0] lvpn, logic [1:0] k, bit fe,
                      logic [VW-1:0] fv, logic [PW-1:0] fp, logic [2:0] fperm,
                      bit fl, string ctx);
    int h, vi;
    bit eh;
    string why;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn; lk_kind = k;
    fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_perm = fperm; flush = fl;
    #1;
    h  = m_find(lvpn);
    eh = lv && (h >= 0);
    chk({ctx, " R1 hit"}, int'(lk_hit), int'(eh));
    chk({ctx, " R2 ppn"}, int'(lk_ppn), eh ? int'(m_ppn[h]) : 0);
    chk({ctx, " R3 fault"}, int'(lk_fault), eh ? int'(!m_allow(m_perm[h], k)) : 0);
    chk({ctx, " R8 dirty"}, int'(lk_dirty), eh ? int'(m_d[h]) : 0);
    vi = m_victim(fv, why);
    chk({ctx, " ", why}, int'(vict_idx), vi);
    chk({ctx, " R9 vict_dirty"}, int'(vict_dirty), int'(m_v[vi] && m_d[vi]));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_u[i] = 1'b0; end
    end else if (fe) begin
      m_tag[vi] = fv; m_ppn[vi] = fp; m_perm[vi] = fperm;
      m_v[vi] = 1'b1; m_d[vi] = 1'b0;
      m_touch(vi);
    end else if (eh) begin
      m_touch(h);
      if (k == 2'd1 && m_allow(m_perm[h], k)) m_d[h] = 1'b1;
    end
  endtask

  task automatic lookup(logic [VW-1:0] v, logic [1:0] k, string ctx);
    step(1'b1, v, k, 1'b0, 6'd63, '0, '0, 1'b0, ctx);
  endtask

  task automatic fill(logic [VW-1:0] v, logic [PW-1:0] p, logic [2:0] pm, string ctx);
    step(1'b0, '0, 2'd0, 1'b1, v, p, pm, 1'b0, ctx);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_u[i] = 0; m_d[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_perm[i] = 0;
    end
    rst = 1'b1; flush = 0; lk_valid = 0; lk_vpn = 0; lk_kind = 0;
    fill_en = 0; fill_vpn = 0; fill_ppn = 0; fill_perm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R13: empty after reset, every VPN misses, victim slot 0.
    #1;
    chk("R13 vict_idx", int'(vict_idx), 0);
    chk("R13 vict_dirty", int'(vict_dirty), 0);
    for (int v = 0; v < 64; v++) lookup(6'(v), 2'(v % 4), "R13");

    // R4/R5/R12: fill eight slots, lookups running alongside without side effects.
    for (int i = 0; i < N; i++)
      step(1'b1, 6'((7 * (i + 7) + 3) % 64), 2'd1, 1'b1, 6'((7 * i + 3) % 64),
           5'(3 * i + 1), 3'(i), 1'b0, "R4 R12");

    // R1/R2/R3/R7/R8: full sweep over every VPN and every access kind.
    for (int v = 0; v < 64; v++)
      for (int k = 0; k < 4; k++) lookup(6'(v), 2'(k), "R7 sweep");

    // R12: store hit on a writable entry during a fill leaves it clean.
    step(1'b1, 6'd17, 2'd1, 1'b1, 6'd60, 5'd9, 3'd7, 1'b0, "R12");
    lookup(6'd17, 2'd0, "R12 check");

    // R6/R9/R10: replacements into a full buffer with stores between.
    for (int i = 0; i < 12; i++) begin
      lookup(6'((7 * (i % N) + 3) % 64), 2'd1, "R8 store");
      fill(6'(40 + i), 5'(i + 11), 3'(i % 8), "R6 R10 refill");
      lookup(6'(40 + i), 2'(i % 4), "R4 new");
    end
    // R10: refill a held tag in place; R9 shows its written mark first.
    lookup(6'd45, 2'd1, "R10 prep");
    fill(6'd45, 5'd30, 3'd7, "R10 inplace");
    lookup(6'd45, 2'd0, "R10 after");

    // R11: flush wins over a same-cycle fill and lookup.
    step(1'b1, 6'd45, 2'd1, 1'b1, 6'd2, 5'd3, 3'd7, 1'b1, "R11 flush");
    for (int v = 0; v < 64; v++) lookup(6'(v), 2'd0, "R11 empty");

    // R5 after flush: slots refill from 0 upward.
    for (int i = 0; i < 3; i++) fill(6'(20 + i), 5'(i), 3'd3, "R5 post-flush");
    for (int i = 0; i < 3; i++) lookup(6'(20 + i), 2'd1, "R8 post-flush");
    lookup(6'd20, 2'd0, "R8 readback");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule